// File: doc/BRIEF.md
# Floating-point minimum/maximum selector

This block picks the larger or the smaller of two IEEE 754 binary floating-point operands. The format is set by one width parameter (16, 32 or 64 bits). A one-bit opcode chooses between maximum and minimum. A small tag travels with each operation and comes back unchanged beside its result. The block does no arithmetic. It checks each operand for NaN, orders the two values by sign, and then orders them by a single unsigned compare of the exponent and mantissa bits.

NaN handling suppresses a single NaN: when only one operand is NaN, the result is the other operand. When both are NaN, the result is one fixed quiet NaN. A parameter adds an optional output register. With the register, results and tags appear one clock after their operands and are qualified by a valid bit. Without it, the path is purely combinational and the valid bit passes straight through.

Top module: `fpsel_top`

## Requirements
- R1: Every valid result is bit-identical to operand a, to operand b, or to the canonical NaN.
- R2: An operand is a NaN when its exponent field is all ones and its mantissa is nonzero. The exponent field is 5, 8 or 11 bits for widths 16, 32 or 64. An infinity (all-ones exponent, zero mantissa) is not a NaN and is ordered like any other value.
- R3: When both operands are NaN, the result is the canonical quiet NaN: sign 0, exponent all ones, mantissa MSB 1 and all other mantissa bits 0 (0x7FC00000 at width 32).
- R4: When exactly one operand is NaN, the result is the other operand, bit for bit, for both maximum and minimum.
- R5: When neither operand is NaN and the sign bits (the MSB) differ, the operand with sign 0 is the larger. This means maximum of +0 and -0 gives +0, and minimum gives -0.
- R6: When neither operand is NaN and the signs match, the lower W-1 bits are compared as an unsigned integer. A larger integer means a larger value for positive operands and a smaller value for negative operands.
- R7: When op_min is 0, the result is the maximum. When op_min is 1, the result is the minimum.
- R8: When the two operands are identical bit patterns, the result equals that pattern.
- R9: With REGISTERED=1, out_valid, out_res and out_tag show the inputs of the previous rising clock edge. A low rst_n at a rising edge clears out_valid at that edge.
- R10: out_tag equals the in_tag that was presented with the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only when REGISTERED=1) |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are present |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_min | input | 1 | 0: maximum, 1: minimum |
| in_tag | input | TAG_W | Transaction tag |
| out_valid | output | 1 | Result is present |
| out_res | output | W | Selected operand or canonical NaN |
| out_tag | output | TAG_W | Tag of this result |

## Verification
Each fault in the NaN detection, the sign ordering or the magnitude compare shows up as a wrong result word, one clock after the operands that expose it. The bench compares every cycle, so a fault is reported on the first operand pair that reaches it. The directed corner cases make sure every path is reached: infinities, signed zeros, single and double NaNs, equal operands, and negative pairs. A stuck or mistimed valid register shows up as out_valid disagreeing with the in_valid of the previous cycle, including the cycle right after a mid-run reset.

// File: rtl/fpsel_pkg.sv
// Shared definitions for the floating-point min/max selector.
// Assumes the width is one of the three binary formats 16, 32 or 64.
package fpsel_pkg;

    // Exponent field width for a given total width
    function automatic int exp_width(input int w);
        if (w == 16)      return 5;
        else if (w == 64) return 11;
        else              return 8;
    endfunction

    // Opcode encoding
    typedef enum logic {
        SEL_MAX = 1'b0,
        SEL_MIN = 1'b1
    } sel_op_e;

endpackage

// File: rtl/fpsel_classify.sv
// Splits one operand into sign, magnitude bits and a NaN flag.
// Assumes EW matches the format of width W.
module fpsel_classify #(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0] val,
    output logic         is_nan,
    output logic         sign,
    output logic [W-2:0] mag
);
    localparam int MW = W - 1 - EW;

    logic [EW-1:0] exp_f;
    logic [MW-1:0] man_f;

    // Field extraction and NaN test (all-ones exponent, nonzero mantissa)
    always_comb begin
        sign   = val[W-1];
        mag    = val[W-2:0];
        exp_f  = val[W-2:MW];
        man_f  = val[MW-1:0];
        is_nan = (&exp_f) && (|man_f);
    end
endmodule

// File: rtl/fpsel_order.sv
// Decides whether operand b is the larger of two non-NaN values.
// Assumes that NaN operands have already been filtered out by the caller.
module fpsel_order #(
    parameter int W = 32
) (
    input  logic         sign_a,
    input  logic         sign_b,
    input  logic [W-2:0] mag_a,
    input  logic [W-2:0] mag_b,
    output logic         b_larger
);
    logic mag_lt;

    // Sign decides first; if the signs match, the magnitude compare decides,
    // inverted when both operands are negative
    always_comb begin
        mag_lt = (mag_a < mag_b);
        if (sign_a != sign_b) b_larger = sign_a;
        else                  b_larger = mag_lt ^ sign_a;
    end
endmodule

// File: rtl/fpsel_stage.sv
// Optional output register for result, tag and valid.
// With REGISTERED=0 it is a plain wire and clk/rst_n are not used.
module fpsel_stage #(
    parameter int W          = 32,
    parameter int TAG_W      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_valid,
    input  logic [W-1:0]     d_res,
    input  logic [TAG_W-1:0] d_tag,
    output logic             q_valid,
    output logic [W-1:0]     q_res,
    output logic [TAG_W-1:0] q_tag
);
    generate
        if (REGISTERED) begin : g_reg
            // Capture one result per clock; only valid is reset
            always_ff @(posedge clk) begin
                if (!rst_n) q_valid <= 1'b0;
                else        q_valid <= d_valid;
                q_res <= d_res;
                q_tag <= d_tag;
            end
        end else begin : g_wire
            // Pass straight through
            always_comb begin
                q_valid = d_valid;
                q_res   = d_res;
                q_tag   = d_tag;
            end
        end
    endgenerate
endmodule

// File: rtl/fpsel_top.sv
// Floating-point min/max selector. A single NaN is suppressed (the other
// operand wins), and two NaNs give a canonical quiet NaN. Ordering is by sign,
// then by an unsigned compare of exponent and mantissa.
// Assumes W is 16, 32 or 64.
module fpsel_top #(
    parameter int W          = 32,
    parameter int TAG_W      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic             op_min,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [W-1:0]     out_res,
    output logic [TAG_W-1:0] out_tag
);
    localparam int EW = fpsel_pkg::exp_width(W);
    localparam int MW = W - 1 - EW;
    localparam logic [W-1:0] CANON_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    logic         a_nan, b_nan, a_sign, b_sign, b_larger;
    logic [W-2:0] a_mag, b_mag;
    logic [W-1:0] sel_res;

    fpsel_classify #(.W(W), .EW(EW)) u_cls_a (
        .val(op_a), .is_nan(a_nan), .sign(a_sign), .mag(a_mag)
    );
    fpsel_classify #(.W(W), .EW(EW)) u_cls_b (
        .val(op_b), .is_nan(b_nan), .sign(b_sign), .mag(b_mag)
    );

    fpsel_order #(.W(W)) u_order (
        .sign_a(a_sign), .sign_b(b_sign),
        .mag_a(a_mag), .mag_b(b_mag),
        .b_larger(b_larger)
    );

    // Result selection: NaN rules first, then ordered choice per opcode
    always_comb begin
        if (a_nan && b_nan)                                  sel_res = CANON_NAN;
        else if (a_nan)                                      sel_res = op_b;
        else if (b_nan)                                      sel_res = op_a;
        else if (b_larger ^ (op_min == fpsel_pkg::SEL_MIN))  sel_res = op_b;
        else                                                 sel_res = op_a;
    end

    fpsel_stage #(.W(W), .TAG_W(TAG_W), .REGISTERED(REGISTERED)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .d_valid(in_valid), .d_res(sel_res), .d_tag(in_tag),
        .q_valid(out_valid), .q_res(out_res), .q_tag(out_tag)
    );
endmodule

// File: rtl/fpsel_checker.sv
// Temporal checks for fpsel_top, attached with bind. Keeps its own copy of
// the operands lined up with the output latency.
module fpsel_checker #(
    parameter int W          = 32,
    parameter int TAG_W      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic             op_min,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             out_valid,
    input  logic [W-1:0]     out_res,
    input  logic [TAG_W-1:0] out_tag
);
    localparam int EW = fpsel_pkg::exp_width(W);
    localparam int MW = W - 1 - EW;
    localparam logic [W-1:0] CANON_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    logic [W-1:0]     a_ref, b_ref;
    logic [TAG_W-1:0] t_ref;
    logic             an, bn;

    generate
        if (REGISTERED) begin : g_lat
            // Hold the operands of the previous edge
            always_ff @(posedge clk) begin
                a_ref <= op_a;
                b_ref <= op_b;
                t_ref <= in_tag;
            end
            p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid == $past(in_valid)));
        end else begin : g_comb
            always_comb begin
                a_ref = op_a;
                b_ref = op_b;
                t_ref = in_tag;
            end
            p_valid_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
        end
    endgenerate

    // NaN flags of the aligned operands
    always_comb begin
        an = (&a_ref[W-2:MW]) && (|a_ref[MW-1:0]);
        bn = (&b_ref[W-2:MW]) && (|b_ref[MW-1:0]);
    end

    p_member_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_res == a_ref || out_res == b_ref || out_res == CANON_NAN));
    p_both_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && an && bn) |-> (out_res == CANON_NAN));
    p_one_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && an && !bn) |-> (out_res == b_ref));
    p_other_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bn && !an) |-> (out_res == a_ref));
    p_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag == t_ref));
endmodule

bind fpsel_top fpsel_checker #(.W(W), .TAG_W(TAG_W), .REGISTERED(REGISTERED)) u_fpsel_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_min(op_min), .in_tag(in_tag), .out_valid(out_valid),
    .out_res(out_res), .out_tag(out_tag)
);

// File: tb/tb_fpsel_top.sv
// Bench for fpsel_top at width 32 with the output register enabled.
module tb_fpsel_top;
    localparam int W     = 32;
    localparam int TAG_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [W-1:0]     op_a, op_b;
    logic             op_min;
    logic [TAG_W-1:0] in_tag;
    logic             out_valid;
    logic [W-1:0]     out_res;
    logic [TAG_W-1:0] out_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit               v;
        logic [W-1:0]     res;
        logic [TAG_W-1:0] tag;
        string            req;
    } exp_t;
    exp_t pend[$];

    fpsel_top #(.W(W), .TAG_W(TAG_W), .REGISTERED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_min(op_min), .in_tag(in_tag), .out_valid(out_valid),
        .out_res(out_res), .out_tag(out_tag)
    );

    always #5 clk = ~clk;

    function automatic bit is_nan32(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    // Order-preserving key: negative values flipped, positive values offset
    function automatic logic [31:0] key(input logic [31:0] x);
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic mn, input logic [TAG_W-1:0] t);
        exp_t e;
        e.v = 1'b1; e.tag = t;
        if (is_nan32(a) && is_nan32(b)) begin e.res = 32'h7FC0_0000; e.req = "R3"; end
        else if (is_nan32(a))           begin e.res = b; e.req = "R4"; end
        else if (is_nan32(b))           begin e.res = a; e.req = "R4"; end
        else begin
            if (a == b)           e.req = "R8";
            else if (a[31] != b[31]) e.req = "R5";
            else                  e.req = "R6";
            if (!mn) e.res = (key(b) > key(a)) ? b : a;
            else     e.res = (key(b) < key(a)) ? b : a;
        end
        return e;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // One cycle: check the output of the previous cycle, then drive new inputs
    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                        input logic mn, input logic [TAG_W-1:0] t);
        exp_t e;
        @(negedge clk);
        if (pend.size() > 0) begin
            e = pend.pop_front();
            chk("R9 valid", {63'd0, out_valid}, {63'd0, e.v});
            if (e.v) begin
                chk({e.req, (mn ? "" : ""), " R1 R7 result"}, {32'd0, out_res}, {32'd0, e.res});
                chk("R10 tag", {60'd0, out_tag}, {60'd0, e.tag});
            end
        end
        in_valid = v; op_a = a; op_b = b; op_min = mn; in_tag = t;
        if (v) pend.push_back(model(a, b, mn, t));
        else begin e.v = 1'b0; e.res = '0; e.tag = '0; e.req = "R9"; pend.push_back(e); end
    endtask

    // Both opcodes for one operand pair
    task automatic both(input logic [31:0] a, input logic [31:0] b);
        step(1'b1, a, b, 1'b0, 4'(a[3:0] ^ b[7:4]));
        step(1'b1, a, b, 1'b1, 4'(a[7:4] ^ b[3:0]));
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; op_min = 1'b0; in_tag = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        // R2: infinities are ordered, NaNs suppressed
        both(32'h7F80_0000, 32'h3F80_0000);
        both(32'hFF80_0000, 32'hBF80_0000);
        both(32'h7F80_0001, 32'hC000_0000);
        both(32'h4000_0000, 32'hFFC0_0000);
        // R3: two NaNs of various kinds
        both(32'h7FC0_0000, 32'hFF80_1234);
        both(32'h7F80_0001, 32'h7FFF_FFFF);
        // R5: signed zeros and mixed signs
        both(32'h0000_0000, 32'h8000_0000);
        both(32'h8000_0000, 32'h0000_0000);
        both(32'hC120_0000, 32'h3F00_0000);
        // R6: same sign, positive and negative
        both(32'h3F80_0000, 32'h4000_0000);
        both(32'hBF80_0000, 32'hC000_0000);
        both(32'h0000_0001, 32'h0000_0002);
        // R8: identical operands
        both(32'h4049_0FDB, 32'h4049_0FDB);
        both(32'hC049_0FDB, 32'hC049_0FDB);
        // R9: idle cycle reports invalid
        step(1'b0, 32'h1, 32'h2, 1'b0, 4'h0);
        // R9: mid-run reset clears valid
        step(1'b1, 32'h3F80_0000, 32'h4000_0000, 1'b0, 4'h5);
        @(negedge clk);
        void'(pend.pop_front());
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid-run reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        // Random operands, with some NaN and sign patterns forced
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            if (i % 7 == 0) a[30:23] = 8'hFF;
            if (i % 11 == 0) b[30:23] = a[30:23];
            if (i % 5 == 0) b[31] = a[31];
            step((i % 13) != 0, a, b, 1'($urandom), 4'($urandom));
        end
        step(1'b0, '0, '0, 1'b0, '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule